// File: doc/BRIEF.md
# Camera Frame Capture Writer

This block takes the parallel output of an image sensor (a pixel clock, a line-valid level, a frame sync level and an 8-bit pixel bus) and stores one frame into an asynchronous 256K x 16 static RAM. All four sensor inputs are brought into the system clock domain through a two-flop synchronizer. The pixel clock, line and frame levels each pass through a stability filter, so a short glitch never reaches the capture logic. The frame sync sits low while a frame is valid and rises briefly to mark a new frame. A filtered rising edge of the frame sync is the start-of-frame event.

Software pulses `capture_start` to arm the writer. The next start-of-frame reloads the address counter and opens capture, and the start-of-frame after that closes capture and pulses `capture_done`. Every pixel taken on the selected pixel clock edge, while the line is valid and the frame sync is low, becomes its own byte write. The first pixel of each pair goes to the low byte and the second to the high byte of the same word. The address then moves up from zero, or, when the flip parameter is set, down from the top of the frame region, which stores the picture upside down.

Top module: `cam_frame_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are high, and `capture_busy` and `capture_done` are low.
- R2: A new level on `sens_pclk`, `sens_line` or `sens_frame` takes effect only after three consecutive equal samples at the output of the synchronizer. A pulse of one or two system clocks on any of them causes no write, no reload and no `capture_done`.
- R3: A one-cycle `capture_start` arms the block, and capture begins at the next filtered rising edge of `sens_frame`. Pixels arriving before that edge are not written. `capture_start` has no effect while a capture is in progress.
- R4: A pixel is taken only on the pixel clock edge chosen by `PCLK_RISING` (1 = rising, 0 = falling), and only while the filtered line level is high and the filtered frame level is low. The written byte equals the `sens_data` value held around that edge.
- R5: Pixels alternate lanes, starting each frame on the low lane. A low-lane write has `sram_lb_n`=0, `sram_ub_n`=1, the pixel on `sram_dq[7:0]` and zero on `sram_dq[15:8]`. A high-lane write has `sram_ub_n`=0, `sram_lb_n`=1, the pixel on `sram_dq[15:8]` and zero on `sram_dq[7:0]`. Both halves of a pair use the same address.
- R6: With `FLIP`=0, the first word of a frame is at address 0, and the address rises by one after each high-lane write.
- R7: With `FLIP`=1, the first word of a frame is at address `FRAME_WORDS`-1, and the address falls by one after each high-lane write.
- R8: Each write holds `sram_ce_n` low for exactly three clocks: a setup clock with `sram_we_n` high, one clock with `sram_we_n` low, and a hold clock with `sram_we_n` high. Address, data and byte enables stay constant while `sram_ce_n` is low, and `sram_oe_n` stays high.
- R9: Counting the clock edge that first samples a new `sens_pclk` level as edge one, `sram_we_n` is low after the seventh edge. The pixel clock must stay in each level for at least six system clocks.
- R10: During capture, a filtered rising edge of `sens_frame` raises `capture_done` for exactly one cycle and drops `capture_busy`. A new frame is then stored only after a new `capture_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_start | input | 1 | One-cycle pulse that arms capture |
| sens_pclk | input | 1 | Sensor pixel clock, asynchronous |
| sens_frame | input | 1 | Sensor frame sync: low in frame, brief high at frame start |
| sens_line | input | 1 | Sensor line valid, high during a line |
| sens_data | input | 8 | Sensor pixel value |
| sram_addr | output | 18 | SRAM word address |
| sram_dq | output | 16 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, held high |
| sram_ub_n | output | 1 | SRAM upper byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower byte enable, active low |
| capture_busy | output | 1 | High while armed or capturing |
| capture_done | output | 1 | One-cycle pulse at the end of a captured frame |

## Verification
A pixel clock edge driven by the bench produces its write strobe after seven clock edges: two synchronizer stages, three filter samples, one cycle to latch the request and one setup clock. The end-of-frame pulse follows a frame sync rise after six edges. A behavioural model pushes the expected address, lane and byte for every pixel it considers valid. On every clock, away from the edge, the bench pops one expected entry for each observed strobe, so the check does not depend on a fixed delay. One pixel is timed separately against the seven-edge figure. The stimulus keeps each input level for at least six clocks, except for the deliberate glitches, so every real event settles before the next one.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int PIX_W  = 8;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_RUN
    } cap_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SETUP,
        WR_STROBE,
        WR_HOLD
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PIX_W-1:0]  pix;
        logic              upper;
    } wr_req_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic down);
        return down ? (a - 1'b1) : (a + 1'b1);
    endfunction

    function automatic logic [DATA_W-1:0] place_pix(input logic [PIX_W-1:0] p,
                                                    input logic upper);
        return upper ? {p, {PIX_W{1'b0}}} : {{PIX_W{1'b0}}, p};
    endfunction

endpackage

// File: rtl/cfw_sync_filter.sv
module cfw_sync_filter #(
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl
);
    localparam int CNT_W = $clog2(STABLE_SAMPLES + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic                   sampled;
    logic [CNT_W-1:0]       cnt;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], din};
    end

    assign sampled = chain[SYNC_STAGES-1];

    // a differing sample advances the count; a matching one clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else if (sampled == lvl) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(STABLE_SAMPLES - 1)) begin
            lvl <= sampled;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (STABLE_SAMPLES == 3) begin : g_chk
            assert_three_stable_R2: assert property (@(posedge clk) disable iff (rst)
                (lvl != $past(lvl)) |->
                    ($past(sampled) == lvl && $past(sampled, 2) == lvl && $past(sampled, 3) == lvl));
        end
    endgenerate

endmodule

// File: rtl/cfw_capture_ctrl.sv
module cfw_capture_ctrl
    import cfw_pkg::*;
#(
    parameter bit FLIP        = 1'b0,
    parameter int FRAME_WORDS = 262144
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_start,
    input  logic             sof,
    input  logic             pix_evt,
    input  logic             line_lvl,
    input  logic             frame_lvl,
    input  logic [PIX_W-1:0] pix_data,
    output logic             req_valid,
    output wr_req_t          req,
    output logic             capture_busy,
    output logic             capture_done
);
    localparam logic [ADDR_W-1:0] START_ADDR = FLIP ? ADDR_W'(FRAME_WORDS - 1) : '0;

    cap_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic              upper;

    assign req_valid    = (state == CAP_RUN) && pix_evt && line_lvl && !frame_lvl && !sof;
    assign req          = '{addr: addr, pix: pix_data, upper: upper};
    assign capture_busy = (state != CAP_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= CAP_IDLE;
            addr         <= '0;
            upper        <= 1'b0;
            capture_done <= 1'b0;
        end else begin
            capture_done <= 1'b0;
            unique case (state)
                CAP_IDLE: begin
                    if (capture_start) state <= CAP_ARMED;
                end
                CAP_ARMED: begin
                    if (sof) begin
                        state <= CAP_RUN;
                        addr  <= START_ADDR;
                        upper <= 1'b0;
                    end
                end
                CAP_RUN: begin
                    if (sof) begin
                        state        <= CAP_IDLE;
                        capture_done <= 1'b1;
                    end else if (req_valid) begin
                        upper <= ~upper;
                        if (upper) addr <= step_addr(addr, FLIP);
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        capture_done |=> !capture_done);

    assert_done_ends_run_R10: assert property (@(posedge clk) disable iff (rst)
        capture_done |-> ($past(state) == CAP_RUN && state == CAP_IDLE));

    assert_arm_by_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(capture_busy) |-> $past(capture_start));

endmodule

// File: rtl/cfw_sram_writer.sv
module cfw_sram_writer
    import cfw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  wr_req_t           req,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n
);
    wr_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WR_IDLE;
            sram_addr <= '0;
            sram_dq   <= '0;
            sram_ce_n <= 1'b1;
            sram_we_n <= 1'b1;
            sram_ub_n <= 1'b1;
            sram_lb_n <= 1'b1;
        end else begin
            unique case (state)
                WR_IDLE: begin
                    if (req_valid) begin
                        state     <= WR_SETUP;
                        sram_addr <= req.addr;
                        sram_dq   <= place_pix(req.pix, req.upper);
                        sram_ub_n <= ~req.upper;
                        sram_lb_n <= req.upper;
                        sram_ce_n <= 1'b0;
                    end
                end
                WR_SETUP: begin
                    state     <= WR_STROBE;
                    sram_we_n <= 1'b0;
                end
                WR_STROBE: begin
                    state     <= WR_HOLD;
                    sram_we_n <= 1'b1;
                end
                WR_HOLD: begin
                    state     <= WR_IDLE;
                    sram_ce_n <= 1'b1;
                    sram_ub_n <= 1'b1;
                    sram_lb_n <= 1'b1;
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

    assert_we_inside_ce_R8: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n);

    assert_setup_clock_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> !$past(sram_ce_n));

    assert_hold_clock_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> !sram_ce_n);

    assert_bus_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && !$past(sram_ce_n)) |->
            ($stable(sram_addr) && $stable(sram_dq) && $stable(sram_ub_n) && $stable(sram_lb_n)));

    assert_one_lane_R5: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> (sram_ub_n != sram_lb_n));

    assert_req_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (state == WR_IDLE));

endmodule

// File: rtl/cam_frame_writer.sv
module cam_frame_writer
    import cfw_pkg::*;
#(
    parameter bit FLIP           = 1'b0,
    parameter bit PCLK_RISING    = 1'b1,
    parameter int FRAME_WORDS    = 262144,
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        capture_start,
    input  logic        sens_pclk,
    input  logic        sens_frame,
    input  logic        sens_line,
    input  logic [7:0]  sens_data,
    output logic [17:0] sram_addr,
    output logic [15:0] sram_dq,
    output logic        sram_ce_n,
    output logic        sram_we_n,
    output logic        sram_oe_n,
    output logic        sram_ub_n,
    output logic        sram_lb_n,
    output logic        capture_busy,
    output logic        capture_done
);
    localparam int NUM_REF = 3;   // bit 0 pixel clock, bit 1 line, bit 2 frame

    logic [NUM_REF-1:0] ref_raw, ref_lvl;
    logic               pclk_q, frame_q;
    logic               pix_evt, sof;
    logic [PIX_W-1:0]   dpipe [SYNC_STAGES];
    logic               req_valid;
    wr_req_t            req;

    assign ref_raw = {sens_frame, sens_line, sens_pclk};

    generate
        for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
            cfw_sync_filter #(
                .SYNC_STAGES    (SYNC_STAGES),
                .STABLE_SAMPLES (STABLE_SAMPLES)
            ) u_filt (
                .clk (clk),
                .rst (rst),
                .din (ref_raw[g]),
                .lvl (ref_lvl[g])
            );
        end
    endgenerate

    // pixel bus takes the same synchronizer depth; it is held steady across the edge
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) dpipe[i] <= '0;
        end else begin
            dpipe[0] <= sens_data;
            for (int i = 1; i < SYNC_STAGES; i++) dpipe[i] <= dpipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            pclk_q  <= ref_lvl[0];
            frame_q <= ref_lvl[2];
        end
    end

    assign pix_evt = PCLK_RISING ? (ref_lvl[0] && !pclk_q) : (!ref_lvl[0] && pclk_q);
    assign sof     = ref_lvl[2] && !frame_q;

    cfw_capture_ctrl #(
        .FLIP        (FLIP),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .capture_start (capture_start),
        .sof           (sof),
        .pix_evt       (pix_evt),
        .line_lvl      (ref_lvl[1]),
        .frame_lvl     (ref_lvl[2]),
        .pix_data      (dpipe[SYNC_STAGES-1]),
        .req_valid     (req_valid),
        .req           (req),
        .capture_busy  (capture_busy),
        .capture_done  (capture_done)
    );

    cfw_sram_writer u_wr (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .sram_addr (sram_addr),
        .sram_dq   (sram_dq),
        .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n),
        .sram_ub_n (sram_ub_n),
        .sram_lb_n (sram_lb_n)
    );

    assign sram_oe_n = 1'b1;

endmodule

// File: tb/cam_frame_writer_tb_top.sv
module cam_frame_writer_tb_top;

    localparam int FLIP_WORDS = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       rst = 1'b1;
    logic       cap_start = 1'b0;
    logic       pclk = 1'b0, frame = 1'b0, line = 1'b0;
    logic [7:0] data = 8'h00;

    logic [17:0] a_addr, b_addr;
    logic [15:0] a_dq, b_dq;
    logic a_ce_n, a_we_n, a_oe_n, a_ub_n, a_lb_n, a_busy, a_done;
    logic b_ce_n, b_we_n, b_oe_n, b_ub_n, b_lb_n, b_busy, b_done;

    cam_frame_writer #(.FLIP(1'b0), .PCLK_RISING(1'b1)) dut_i (
        .clk(clk), .rst(rst), .capture_start(cap_start),
        .sens_pclk(pclk), .sens_frame(frame), .sens_line(line), .sens_data(data),
        .sram_addr(a_addr), .sram_dq(a_dq), .sram_ce_n(a_ce_n), .sram_we_n(a_we_n),
        .sram_oe_n(a_oe_n), .sram_ub_n(a_ub_n), .sram_lb_n(a_lb_n),
        .capture_busy(a_busy), .capture_done(a_done));

    // flipped store, fed the inverted pixel clock and sampling on its falling edge
    cam_frame_writer #(.FLIP(1'b1), .PCLK_RISING(1'b0), .FRAME_WORDS(FLIP_WORDS)) dut_flip_i (
        .clk(clk), .rst(rst), .capture_start(cap_start),
        .sens_pclk(~pclk), .sens_frame(frame), .sens_line(line), .sens_data(data),
        .sram_addr(b_addr), .sram_dq(b_dq), .sram_ce_n(b_ce_n), .sram_we_n(b_we_n),
        .sram_oe_n(b_oe_n), .sram_ub_n(b_ub_n), .sram_lb_n(b_lb_n),
        .capture_busy(b_busy), .capture_done(b_done));

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural model
    int  q_addr[2][$], q_lane[2][$], q_data[2][$];
    bit  model_arm = 0, model_cap = 0;
    int  ma0 = 0, ma1 = 0;
    bit  mu = 0;
    int  n_exp = 0, exp_done = 0;
    int  strobes[2] = '{0, 0};
    int  ce_low[2]  = '{0, 0};
    int  dones[2]   = '{0, 0};
    bit  prev_done[2] = '{0, 0};
    int  oe_bad = 0;
    bit  lat_arm = 0, lat_seen = 0;
    int  lat_start = 0;

    task automatic cmp(int w, logic [17:0] addr, logic ub_n, logic lb_n, logic [15:0] dq);
        int ea, el, ed, al, ad, other;
        if (q_addr[w].size() == 0) begin
            check(0, "R2 R3", $sformatf("unexpected write dut%0d addr", w), addr, -1);
            return;
        end
        ea = q_addr[w].pop_front();
        el = q_lane[w].pop_front();
        ed = q_data[w].pop_front();
        al = (!lb_n && ub_n) ? 0 : ((!ub_n && lb_n) ? 1 : 2);
        ad = (al == 1) ? int'(dq[15:8]) : int'(dq[7:0]);
        other = (al == 1) ? int'(dq[7:0]) : int'(dq[15:8]);
        check(al == el, "R5", $sformatf("lane dut%0d", w), al, el);
        check(other == 0, "R5", $sformatf("unused lane dut%0d", w), other, 0);
        check(ad == ed, "R4", $sformatf("pixel byte dut%0d", w), ad, ed);
        if (w == 0) check(int'(addr) == ea, "R6", "rising address", addr, ea);
        else        check(int'(addr) == ea, "R7", "flipped address", addr, ea);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (a_oe_n !== 1'b1 || b_oe_n !== 1'b1) oe_bad++;
            if (!a_ce_n) ce_low[0]++;
            if (!b_ce_n) ce_low[1]++;
            if (a_done) begin
                dones[0]++;
                if (prev_done[0]) check(0, "R10", "done width dut0", 2, 1);
            end
            if (b_done) begin
                dones[1]++;
                if (prev_done[1]) check(0, "R10", "done width dut1", 2, 1);
            end
            prev_done[0] = a_done;
            prev_done[1] = b_done;
            if (!a_we_n) begin
                strobes[0]++;
                if (lat_arm) begin
                    lat_arm  = 0;
                    lat_seen = 1;
                    check(cyc - lat_start == 7, "R9", "strobe latency", cyc - lat_start, 7);
                end
                cmp(0, a_addr, a_ub_n, a_lb_n, a_dq);
            end
            if (!b_we_n) begin
                strobes[1]++;
                cmp(1, b_addr, b_ub_n, b_lb_n, b_dq);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pix(logic [7:0] d, bit measure);
        data = d;
        pclk = 1'b0;
        tick(6);
        pclk = 1'b1;
        if (measure) begin
            lat_start = cyc;
            lat_arm   = 1;
        end
        if (model_cap && line && !frame) begin
            q_addr[0].push_back(ma0);
            q_addr[1].push_back(ma1);
            q_lane[0].push_back(int'(mu));
            q_lane[1].push_back(int'(mu));
            q_data[0].push_back(int'(d));
            q_data[1].push_back(int'(d));
            if (mu) begin
                ma0++;
                ma1--;
            end
            mu = ~mu;
            n_exp++;
        end
        tick(6);
    endtask

    task automatic send_line(int n, int base, bit measure);
        line = 1'b1;
        tick(2);
        for (int i = 0; i < n; i++) send_pix(8'(base + i), measure && (i == 0));
        line = 1'b0;
        tick(6);
    endtask

    task automatic start_cap();
        cap_start = 1'b1;
        tick(1);
        cap_start = 1'b0;
        if (!model_cap) model_arm = 1;
        tick(2);
    endtask

    task automatic frame_pulse();
        frame = 1'b1;
        tick(4);
        frame = 1'b0;
        if (model_cap) begin
            model_cap = 0;
            exp_done++;
        end else if (model_arm) begin
            model_arm = 0;
            model_cap = 1;
            ma0 = 0;
            ma1 = FLIP_WORDS - 1;
            mu  = 0;
        end
        tick(8);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check(a_ce_n && a_we_n && a_oe_n && a_ub_n && a_lb_n, "R1", "sram controls idle dut0",
              {a_ce_n, a_we_n, a_oe_n, a_ub_n, a_lb_n}, 31);
        check(b_ce_n && b_we_n && b_oe_n && b_ub_n && b_lb_n, "R1", "sram controls idle dut1",
              {b_ce_n, b_we_n, b_oe_n, b_ub_n, b_lb_n}, 31);
        check(!a_busy && !a_done && !b_busy && !b_done, "R1", "status idle",
              {a_busy, a_done, b_busy, b_done}, 0);
        tick(10);

        // R3: nothing stored while not armed, nor while armed before the frame start
        frame_pulse();
        send_line(4, 8'h20, 0);
        check(strobes[0] == 0, "R3", "writes before arming", strobes[0], 0);
        start_cap();
        check(a_busy && b_busy, "R3", "busy after start", {a_busy, b_busy}, 3);
        send_line(4, 8'h30, 0);
        check(strobes[0] == 0, "R3", "writes before frame start", strobes[0], 0);
        frame_pulse();

        // R4 R5 R6 R7 R9: first line, latency timed on its first pixel
        send_line(6, 8'h10, 1);

        // R4: pixel clock edges with the line low
        send_pix(8'hEE, 0);
        send_pix(8'hEF, 0);

        // R2: pixel clock glitch inside a line
        line = 1'b1;
        tick(6);
        pclk = 1'b0;
        tick(6);
        pclk = 1'b1;
        tick(2);
        pclk = 1'b0;
        tick(6);
        send_pix(8'h5A, 0);
        send_pix(8'hA5, 0);
        line = 1'b0;
        tick(6);

        // R2: line glitch around a pixel clock edge
        pclk = 1'b0;
        tick(6);
        pclk = 1'b1;
        line = 1'b1;
        tick(2);
        line = 1'b0;
        tick(10);
        pclk = 1'b0;
        tick(6);

        // R2: frame glitch mid-frame; R3: start while capturing
        frame = 1'b1;
        tick(2);
        frame = 1'b0;
        tick(10);
        start_cap();
        check(dones[0] == 0 && dones[1] == 0, "R2", "no done from frame glitch", dones[0], 0);

        send_line(5, 8'h40, 0);
        tick(4);
        check(strobes[0] == n_exp, "R2", "write count dut0 mid-frame", strobes[0], n_exp);
        check(strobes[1] == n_exp, "R2", "write count dut1 mid-frame", strobes[1], n_exp);

        frame_pulse();
        check(dones[0] == 1 && dones[1] == 1, "R10", "first done", dones[0] + dones[1], 2);
        check(!a_busy && !b_busy, "R10", "busy cleared", {a_busy, b_busy}, 0);

        // R10: no capture without a new start
        frame_pulse();
        send_line(2, 8'h70, 0);
        check(strobes[0] == n_exp, "R10", "no write when not re-armed", strobes[0], n_exp);

        // second capture restarts the address
        start_cap();
        frame_pulse();
        send_line(4, 8'h80, 0);
        frame_pulse();
        tick(20);

        check(q_addr[0].size() == 0, "R6", "pending writes dut0", q_addr[0].size(), 0);
        check(q_addr[1].size() == 0, "R7", "pending writes dut1", q_addr[1].size(), 0);
        check(strobes[0] == n_exp, "R4", "total writes dut0", strobes[0], n_exp);
        check(strobes[1] == n_exp, "R4", "total writes dut1", strobes[1], n_exp);
        check(dones[0] == exp_done, "R10", "done count dut0", dones[0], exp_done);
        check(dones[1] == exp_done, "R10", "done count dut1", dones[1], exp_done);
        check(ce_low[0] == 3 * strobes[0], "R8", "chip select cycles dut0", ce_low[0], 3 * strobes[0]);
        check(ce_low[1] == 3 * strobes[1], "R8", "chip select cycles dut1", ce_low[1], 3 * strobes[1]);
        check(oe_bad == 0, "R8", "output enable low cycles", oe_bad, 0);
        check(lat_seen, "R9", "latency sample taken", lat_seen, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            finished = 1;
            check(0, "watchdog", "cycles", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule